// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the address of each beat of a four-beat burst to a synchronous burst memory. A starting address is captured when a processor-side start strobe or a controller-side start strobe is seen at a rising clock edge. After that capture, the block steps the two least significant address bits internally, one step for each cycle in which the advance input is high. The upper address bits do not change until the next capture.

An order-select input chooses between two wrap schemes. In linear order the low bits count up modulo four from the captured value. In interleaved order the low bits are the captured low bits XOR the beat count. The order select is sampled together with the start address, so it stays fixed for the whole burst. Tie it low to get the default interleaved order. A new address can be captured on any cycle, including the cycle right after an earlier capture. Nothing is lost when that happens.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset, `addr_out` is all zeros, `beat` is 0 and the captured order is interleaved.
- R2: When either `cpu_start` or `ctl_start` is high at a rising edge, `addr_out` equals the sampled `addr_in` and `beat` equals 0 after that edge.
- R3: When both start strobes are high in the same cycle, the result is one capture, identical to the result of a single strobe.
- R4: A capture takes priority over advance. When a strobe and `advance` are high together, `beat` is 0 after the edge.
- R5: With no strobe and `advance` high, `beat` goes up by one modulo 4, so the fourth advance returns it to 0.
- R6: With no strobe and `advance` low, `addr_out` and `beat` keep their values.
- R7: With linear order captured (`order_linear` = 1), the two low bits of `addr_out` equal (captured low bits + `beat`) mod 4.
- R8: With interleaved order captured (`order_linear` = 0), the two low bits of `addr_out` equal the captured low bits XOR `beat`.
- R9: Bits above the two low bits of `addr_out` equal the captured address for the whole burst.
- R10: `order_linear` is sampled only at a capture. A change to it on a cycle without a strobe has no effect on the sequence.
- R11: Captures on consecutive cycles each take effect, and each one restarts `beat` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cpu_start | input | 1 | Processor-side start strobe |
| ctl_start | input | 1 | Controller-side start strobe |
| advance | input | 1 | Step to the next beat |
| order_linear | input | 1 | 1 selects linear order, 0 selects interleaved order; sampled at a capture |
| addr_in | input | ADDR_W | Starting address |
| addr_out | output | ADDR_W | Address of the current beat |
| beat | output | CNT_W | Beat index within the burst, 0 to 3 |

## Verification
The bench sweeps every starting low-bit value under both orders and with every strobe combination. It walks each burst through all four beats and past the wrap. A design that added instead of XORing, or the reverse, would give wrong addresses from beat 1 onward for starting values 1 and 3. A counter that saturated instead of wrapping would stay at 3 on the fourth advance. The bench also drives a strobe and advance together. If advance won, that case would show beat 1 instead of 0. It changes the order select in the middle of a burst, which catches an order that is not latched at capture. It runs back-to-back captures to catch a load that is dropped after an earlier capture, and hold cycles to catch a counter that moves without advance.

// File: rtl/burst_pkg.sv
package burst_pkg;

  // Captured wrap scheme for the low address bits.
  typedef enum logic {
    ORD_INTERLEAVE = 1'b0,
    ORD_LINEAR     = 1'b1
  } burst_order_e;

  // Per-cycle command decoded from the strobes and advance.
  typedef struct packed {
    logic load;
    logic step;
  } burst_cmd_t;

endpackage

// File: rtl/burst_rst_sync.sv
module burst_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] sync_q;

  // Assert asynchronously; release after STAGES rising edges.
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = sync_q[STAGES-1];

endmodule

// File: rtl/burst_load_ctrl.sv
module burst_load_ctrl
  import burst_pkg::*;
(
  input  logic       cpu_start,
  input  logic       ctl_start,
  input  logic       advance,
  output burst_cmd_t cmd
);

  // Either strobe captures. A capture masks advance.
  always_comb begin
    cmd.load = cpu_start | ctl_start;
    cmd.step = advance & ~(cpu_start | ctl_start);
  end

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  burst_cmd_t       cmd,
  output logic [CNT_W-1:0] beat_o
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] beat_q, beat_d;
  logic             beat_en;

  always_comb begin
    beat_en = cmd.load | cmd.step;
    beat_d  = beat_q;
    if (cmd.load)      beat_d = '0;
    else if (cmd.step) beat_d = beat_q + ONE;  // wraps modulo 2**CNT_W
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)      beat_q <= '0;
    else if (beat_en) beat_q <= beat_d;
  end

  assign beat_o = beat_q;

  // R2 R4: a capture restarts the burst even when advance is high
  a_r4_load_restarts: assert property (@(posedge clk) disable iff (!rst_ni)
    cmd.load |=> (beat_q == '0));

  // R5: advance increments the beat modulo the burst length
  a_r5_step_wraps: assert property (@(posedge clk) disable iff (!rst_ni)
    cmd.step |=> (beat_q == $past(beat_q) + ONE));

  // R6: no command means no movement
  a_r6_beat_holds: assert property (@(posedge clk) disable iff (!rst_ni)
    (!cmd.load && !cmd.step) |=> $stable(beat_q));

endmodule

// File: rtl/burst_addr_latch.sv
module burst_addr_latch
  import burst_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  burst_cmd_t        cmd,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              order_linear_i,
  output logic [ADDR_W-1:0] base_o,
  output burst_order_e      order_o
);

  logic [ADDR_W-1:0] base_q, base_d;
  burst_order_e      order_q, order_d;

  always_comb begin
    base_d  = cmd.load ? addr_i : base_q;
    order_d = cmd.load ? (order_linear_i ? ORD_LINEAR : ORD_INTERLEAVE) : order_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      order_q <= ORD_INTERLEAVE;
    end else if (cmd.load) begin
      base_q  <= base_d;
      order_q <= order_d;
    end
  end

  assign base_o  = base_q;
  assign order_o = order_q;

  // R9 R10: captured address and order are frozen between captures
  a_r10_order_frozen: assert property (@(posedge clk) disable iff (!rst_ni)
    !cmd.load |=> ($stable(order_q) && $stable(base_q)));

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic [CNT_W-1:0] base_low_i,
  input  logic [CNT_W-1:0] beat_i,
  input  burst_order_e     order_i,
  output logic [CNT_W-1:0] low_o
);

  logic [CNT_W-1:0] lin_low;
  logic [CNT_W-1:0] ilv_low;

  assign lin_low = base_low_i + beat_i;

  for (genvar i = 0; i < CNT_W; i++) begin : g_ilv
    assign ilv_low[i] = base_low_i[i] ^ beat_i[i];
  end

  assign low_o = (order_i == ORD_LINEAR) ? lin_low : ilv_low;

  // R7 R8: the orders agree at beat 0 and differ only after that
  a_r8_first_beat_is_base: assert final (beat_i != '0 || low_o == base_low_i);

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_start,
  input  logic              ctl_start,
  input  logic              advance,
  input  logic              order_linear,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic [CNT_W-1:0]  beat
);

  localparam int HI_W = ADDR_W - CNT_W;

  logic              rst_sync_n;
  burst_cmd_t        cmd;
  logic [ADDR_W-1:0] base;
  burst_order_e      order;
  logic [CNT_W-1:0]  beat_q;
  logic [CNT_W-1:0]  low;

  burst_rst_sync #(.STAGES(2)) u_rst (
    .clk         (clk),
    .rst_ni      (rst_n),
    .rst_sync_no (rst_sync_n)
  );

  burst_load_ctrl u_ctrl (
    .cpu_start (cpu_start),
    .ctl_start (ctl_start),
    .advance   (advance),
    .cmd       (cmd)
  );

  burst_beat_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk    (clk),
    .rst_ni (rst_sync_n),
    .cmd    (cmd),
    .beat_o (beat_q)
  );

  burst_addr_latch #(.ADDR_W(ADDR_W)) u_latch (
    .clk            (clk),
    .rst_ni         (rst_sync_n),
    .cmd            (cmd),
    .addr_i         (addr_in),
    .order_linear_i (order_linear),
    .base_o         (base),
    .order_o        (order)
  );

  burst_order_map #(.CNT_W(CNT_W)) u_map (
    .base_low_i (base[CNT_W-1:0]),
    .beat_i     (beat_q),
    .order_i    (order),
    .low_o      (low)
  );

  assign addr_out = {base[ADDR_W-1:CNT_W], low};
  assign beat     = beat_q;

  // R2 R3: any strobe puts the sampled address on the output
  a_r2_capture_visible: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cpu_start || ctl_start) |=> (addr_out == $past(addr_in) && beat == '0));

  // R9: upper address bits never move without a capture
  a_r9_upper_fixed: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(cpu_start || ctl_start) |=> $stable(addr_out[ADDR_W-1:CNT_W]));

  // R6: full output holds when idle
  a_r6_addr_holds: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(cpu_start || ctl_start || advance) |=> $stable(addr_out));

  a_r1_width_ok: assert final (HI_W > 0);

endmodule

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;

  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cpu_start, ctl_start, advance, order_linear;
  logic [AW-1:0] addr_in;
  logic [AW-1:0] addr_out;
  logic [1:0]    beat;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // Reference model state
  logic [AW-1:0] m_base;
  int            m_beat;
  bit            m_lin;

  always #5 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW), .CNT_W(2)) uut (
    .clk(clk), .rst_n(rst_n), .cpu_start(cpu_start), .ctl_start(ctl_start),
    .advance(advance), .order_linear(order_linear), .addr_in(addr_in),
    .addr_out(addr_out), .beat(beat)
  );

  function automatic logic [AW-1:0] exp_addr();
    int lo = m_base[1:0];
    int nl = m_lin ? ((lo + m_beat) % 4) : (lo ^ m_beat);
    return {m_base[AW-1:2], 2'(nl)};
  endfunction

  task automatic chk(input string req);
    total++;
    if (addr_out !== exp_addr() || beat !== 2'(m_beat)) begin
      bad++;
      $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
               req, addr_out, beat, exp_addr(), m_beat);
    end
  endtask

  task automatic step(input bit cs, input bit ks, input bit adv, input bit lin,
                      input logic [AW-1:0] a);
    @(negedge clk);
    cpu_start = cs; ctl_start = ks; advance = adv; order_linear = lin; addr_in = a;
    @(posedge clk);
    if (cs || ks) begin m_base = a; m_beat = 0; m_lin = lin; end
    else if (adv) m_beat = (m_beat + 1) % 4;
    #1;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cpu_start = 0; ctl_start = 0; advance = 0;
    order_linear = 0; addr_in = '0;
    m_base = '0; m_beat = 0; m_lin = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1 chk("R1 reset");
    // R1: idle cycles after reset keep zero state
    step(0, 0, 0, 1, 16'hFFFF); chk("R1 R6 idle after reset");

    // Sweep: both orders, every low start, every strobe combination
    for (int ord = 0; ord < 2; ord++) begin
      for (int lo = 0; lo < 4; lo++) begin
        for (int sel = 0; sel < 3; sel++) begin
          logic [AW-1:0] a;
          a = {14'(ord * 37 + lo * 91 + sel * 13 + 14'h1234), 2'(lo)};
          step(sel != 1, sel != 0, 0, ord[0], a);
          chk(sel == 2 ? "R3 both strobes" : "R2 single strobe");
          for (int k = 1; k < 4; k++) begin
            step(0, 0, 1, ord[0], ~a);
            chk(ord == 1 ? "R7 R9 linear beat" : "R8 R9 interleaved beat");
          end
          step(0, 0, 0, ord[0], ~a); chk("R6 hold");
          step(0, 0, 0, ~ord[0], a ^ 16'h5555); chk("R6 R10 hold, order toggled");
          step(0, 0, 1, ord[0], ~a); chk("R5 wrap to 0");
        end
      end
    end

    // R4: strobe and advance together
    step(1, 0, 0, 0, 16'h0A02); step(0, 0, 1, 0, 16'h0); step(0, 0, 1, 0, 16'h0);
    step(0, 1, 1, 0, 16'h3C01); chk("R4 load beats advance");
    step(1, 1, 1, 1, 16'h3C03); chk("R4 R3 both strobes and advance");

    // R10: order changes mid-burst ignored
    step(1, 0, 0, 1, 16'h7702);
    step(0, 0, 1, 0, 16'h0); chk("R10 linear kept, select low");
    step(0, 0, 1, 0, 16'h0); chk("R10 linear kept, beat 2");
    step(0, 1, 0, 0, 16'h7701);
    step(0, 0, 1, 1, 16'h0); chk("R10 interleaved kept, select high");
    step(0, 0, 1, 1, 16'h0); chk("R10 interleaved kept, beat 2");

    // R11: back-to-back captures
    for (int i = 0; i < 8; i++) begin
      step(i[0], ~i[0], i[1], i[2], 16'(i * 16'h1357 + 3));
      chk("R11 back-to-back capture");
      step(0, 0, 1, 0, 16'h0); chk("R11 advance after capture");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule